// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation that has missed in the TLB. It takes the
20-bit virtual page number of the missing address and the physical base of the
current page directory. It then walks two levels of page tables in memory
through a plain request/response read port. The upper ten bits of the page
number select a directory entry. If that entry is present, its frame number
gives the base of a page table, and the lower ten bits of the page number
select the final entry within it.

The walk ends in one of two ways. A successful walk returns the final entry so
that the TLB can load it. If either level is not present, the block reports a
fault instead, with a code that names the level that stopped the walk. Only one
walk is in flight at a time, and the request side shows ready only while the
walker is idle. Software fault handling and restarting the instruction belong
to the surrounding system.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `miss_ready_o` is 1. While it is 1, neither `mem_req_o` nor `resp_valid_o` is asserted.
- R2: The first memory read of an accepted miss goes to `dir_base_i + vpn[19:10]*4`. Both values are captured in the cycle the miss is accepted.
- R3: If the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], 12'h000} + vpn[9:0]*4`.
- R4: If the directory entry has bit 0 clear, no second read is issued. The walk ends with `resp_fault_o`=1, `resp_lvl_o`=0 (directory level), and `resp_pte_o` equal to the directory entry.
- R5: If the final entry has bit 0 clear, the walk ends with `resp_fault_o`=1, `resp_lvl_o`=1 (table level), and `resp_pte_o` equal to that entry.
- R6: If the final entry has bit 0 set, the walk ends with `resp_fault_o`=0 and `resp_pte_o` equal to the entry as read. Bits 31:12 hold the frame, bits 2:1 the access rights and bit 3 the user flag; all of them are passed through unchanged.
- R7: `mem_req_o` stays asserted, with a stable `mem_addr_o`, until a cycle in which `mem_req_ready_i` is 1. A memory response is taken in the first cycle `mem_rsp_valid_i` is 1 after the request was accepted.
- R8: While a walk is in progress, `miss_valid_i` is not accepted and `miss_ready_o` is 0. A miss held high is taken only once the walker is back to idle.
- R9: `mem_rsp_valid_i` arriving while no read is outstanding has no effect: the walker stays idle and produces no response.
- R10: `resp_valid_o` is a one-cycle pulse, and `miss_ready_o` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid_i | input | 1 | A TLB miss awaits translation |
| miss_ready_o | output | 1 | Walker idle, miss can be taken |
| miss_vpn_i | input | 20 | Virtual page number of the miss |
| dir_base_i | input | 32 | Physical base of the page directory |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_req_ready_i | input | 1 | Memory takes the request this cycle |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (one entry) |
| resp_valid_o | output | 1 | Walk result pulse |
| resp_fault_o | output | 1 | Walk ended in a fault |
| resp_lvl_o | output | 1 | Faulting level: 0 directory, 1 table |
| resp_pte_o | output | 32 | Final entry, or the entry that faulted |

## Verification
The hardest situations to reach are the ones where timing on the memory side
overlaps the miss handshake. Examples are a miss held high all through a walk,
a read held off by a memory that is not ready, and a response that arrives
while nothing is outstanding. The bench memory model adds a set number of stall
cycles before it accepts a request and a set latency before it answers. It can
also inject an unrequested response while the walker idles.

Walks are run with the miss request held asserted, so that back-to-back
acceptance is exercised. Directory and table entries are placed with the
present bit set or clear, so that both fault levels and the success path are
covered. Page numbers at the ends of the index range are included.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DIR,
        S_WT_DIR,
        S_RD_PTE,
        S_WT_PTE,
        S_DONE,
        S_FAULT
    } walk_st_e;

    localparam logic LVL_DIR = 1'b0;
    localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
    parameter int AW = 32,
    parameter int IW = 10,
    parameter int SH = 2
) (
    input  logic [AW-1:0] base_i,
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] addr_o
);
    // each entry occupies 2**SH bytes
    assign addr_o = base_i + AW'({idx_i, {SH{1'b0}}});
endmodule

// File: rtl/ptw_entry.sv
module ptw_entry #(
    parameter int DW = 32,
    parameter int PB = 12
) (
    input  logic [DW-1:0] ent_i,
    output logic          present_o,
    output logic [DW-1:0] next_base_o
);
    localparam logic [DW-1:0] FRAME_MASK = {{(DW-PB){1'b1}}, {PB{1'b0}}};

    assign present_o   = ent_i[0];
    assign next_base_o = ent_i & FRAME_MASK;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int DIR_BITS  = 10,
    parameter int ENT_LOG2  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      miss_valid_i,
    output logic                      miss_ready_o,
    input  logic [VA_W-PAGE_BITS-1:0] miss_vpn_i,
    input  logic [VA_W-1:0]           dir_base_i,
    output logic                      mem_req_o,
    output logic [VA_W-1:0]           mem_addr_o,
    input  logic                      mem_req_ready_i,
    input  logic                      mem_rsp_valid_i,
    input  logic [VA_W-1:0]           mem_rsp_data_i,
    output logic                      resp_valid_o,
    output logic                      resp_fault_o,
    output logic                      resp_lvl_o,
    output logic [VA_W-1:0]           resp_pte_o
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int TBL_BITS = VPN_W - DIR_BITS;
    localparam int IW = (DIR_BITS > TBL_BITS) ? DIR_BITS : TBL_BITS;

    typedef struct packed {
        walk_st_e         st;
        logic [VPN_W-1:0] vpn;
        logic [VA_W-1:0]  base;
        logic [VA_W-1:0]  pte;
        logic             lvl;
    } walk_t;

    walk_t r_q, r_d;

    logic [IW-1:0]   idx;
    logic            ent_present;
    logic [VA_W-1:0] ent_base;

    assign idx = (r_q.st == S_RD_DIR) ? IW'(r_q.vpn[VPN_W-1 -: DIR_BITS])
                                      : IW'(r_q.vpn[TBL_BITS-1:0]);

    ptw_addr #(.AW(VA_W), .IW(IW), .SH(ENT_LOG2)) u_addr (
        .base_i (r_q.base),
        .idx_i  (idx),
        .addr_o (mem_addr_o)
    );

    ptw_entry #(.DW(VA_W), .PB(PAGE_BITS)) u_entry (
        .ent_i       (mem_rsp_data_i),
        .present_o   (ent_present),
        .next_base_o (ent_base)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (miss_valid_i) begin
                    r_d.st   = S_RD_DIR;
                    r_d.vpn  = miss_vpn_i;
                    r_d.base = dir_base_i;
                end
            end
            S_RD_DIR: if (mem_req_ready_i) r_d.st = S_WT_DIR;
            S_WT_DIR: begin
                if (mem_rsp_valid_i) begin
                    if (ent_present) begin
                        r_d.base = ent_base;
                        r_d.st   = S_RD_PTE;
                    end else begin
                        r_d.pte = mem_rsp_data_i;
                        r_d.lvl = LVL_DIR;
                        r_d.st  = S_FAULT;
                    end
                end
            end
            S_RD_PTE: if (mem_req_ready_i) r_d.st = S_WT_PTE;
            S_WT_PTE: begin
                if (mem_rsp_valid_i) begin
                    r_d.pte = mem_rsp_data_i;
                    r_d.lvl = LVL_TBL;
                    r_d.st  = ent_present ? S_DONE : S_FAULT;
                end
            end
            S_DONE, S_FAULT: r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, vpn: '0, base: '0, pte: '0, lvl: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign miss_ready_o = (r_q.st == S_IDLE);
    assign mem_req_o    = (r_q.st == S_RD_DIR) || (r_q.st == S_RD_PTE);
    assign resp_valid_o = (r_q.st == S_DONE) || (r_q.st == S_FAULT);
    assign resp_fault_o = (r_q.st == S_FAULT);
    assign resp_lvl_o   = r_q.lvl;
    assign resp_pte_o   = r_q.pte;
endmodule

module ptw_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miss_valid_i,
    input logic          miss_ready_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_req_ready_i,
    input logic          resp_valid_o,
    input logic          resp_fault_o,
    input logic [AW-1:0] resp_pte_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready_o |-> (!mem_req_o && !resp_valid_o));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_req_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R8
    accept_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miss_ready_o) |-> $past(miss_valid_i));

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> (!resp_valid_o && miss_ready_o));

    // R6
    ok_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && !resp_fault_o) |-> resp_pte_o[0]);

    // R4 R5
    fault_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_fault_o) |-> !resp_pte_o[0]);
endmodule

bind ptw_walker ptw_walker_chk #(.AW(VA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .miss_valid_i    (miss_valid_i),
    .miss_ready_o    (miss_ready_o),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .resp_valid_o    (resp_valid_o),
    .resp_fault_o    (resp_fault_o),
    .resp_pte_o      (resp_pte_o)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [19:0] miss_vpn = '0;
    logic [31:0] dir_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid, resp_fault, resp_lvl;
    logic [31:0] resp_pte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
        .miss_vpn_i(miss_vpn), .dir_base_i(dir_base),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_req_ready_i(mem_req_ready), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data),
        .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
        .resp_lvl_o(resp_lvl), .resp_pte_o(resp_pte)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // backing memory
    logic [31:0] pmem [logic [31:0]];
    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // memory model: stalls, latency, stray responses
    int lat = 0, stall_cfg = 0, stall_ct = 0, cd = 0;
    int stray_req = 0, stray_done = 0;
    bit pend = 0, req_seen = 0;
    logic [31:0] paddr = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 0; req_seen = 0; mem_rsp_valid = 0; mem_req_ready = 0;
        end else begin
            mem_rsp_valid = 0;
            if (pend) begin
                if (cd == 0) begin
                    mem_rsp_valid = 1; mem_rsp_data = rd(paddr); pend = 0;
                end else cd--;
            end else if (stray_req != stray_done) begin
                mem_rsp_valid = 1; mem_rsp_data = 32'h0000_1001; stray_done++;
            end
            if (mem_req && !req_seen) begin req_seen = 1; stall_ct = stall_cfg; end
            if (stall_ct > 0) begin mem_req_ready = 0; stall_ct--; end
            else mem_req_ready = 1;
            if (mem_req && mem_req_ready) begin
                pend = 1; cd = lat; paddr = mem_addr; req_seen = 0;
            end
        end
    end

    // behavioural reference: phase 0 idle,1 dir req,2 dir wait,3 pte req,4 pte wait,5 ok,6 fault
    int ph = 0;
    logic [19:0] m_vpn = '0;
    logic [31:0] m_base = '0, m_pte = '0;
    logic        m_lvl = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_pte = '0; m_lvl = 0;
        end else begin
            case (ph)
                0: if (miss_valid) begin ph = 1; m_vpn = miss_vpn; m_base = dir_base; end
                1: if (mem_req_ready) ph = 2;
                2: if (mem_rsp_valid) begin
                       if (mem_rsp_data[0]) begin
                           m_base = mem_rsp_data & 32'hFFFF_F000; ph = 3;
                       end else begin
                           m_pte = mem_rsp_data; m_lvl = 0; ph = 6;
                       end
                   end
                3: if (mem_req_ready) ph = 4;
                4: if (mem_rsp_valid) begin
                       m_pte = mem_rsp_data; m_lvl = 1;
                       ph = mem_rsp_data[0] ? 5 : 6;
                   end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(miss_ready == (ph == 0), "R1/R8 ready", 32'(miss_ready), 32'(ph == 0));
            chk(mem_req == (ph == 1 || ph == 3), "R7 req", 32'(mem_req), 32'(ph == 1 || ph == 3));
            if (ph == 1)
                chk(mem_addr == m_base + 32'(m_vpn[19:10]) * 4, "R2 dir addr",
                    mem_addr, m_base + 32'(m_vpn[19:10]) * 4);
            if (ph == 3)
                chk(mem_addr == m_base + 32'(m_vpn[9:0]) * 4, "R3 pte addr",
                    mem_addr, m_base + 32'(m_vpn[9:0]) * 4);
            chk(resp_valid == (ph == 5 || ph == 6), "R10 resp_valid",
                32'(resp_valid), 32'(ph == 5 || ph == 6));
            if (ph == 5 || ph == 6) begin
                chk(resp_fault == (ph == 6), "R4/R5 fault", 32'(resp_fault), 32'(ph == 6));
                chk(resp_pte == m_pte, "R6 pte", resp_pte, m_pte);
                if (ph == 6) chk(resp_lvl == m_lvl, "R4/R5 lvl", 32'(resp_lvl), 32'(m_lvl));
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    // one walk with an independent expectation from memory contents
    task automatic walk(input logic [19:0] vpn, input logic [31:0] base);
        logic [31:0] de, pe, exp_pte;
        bit exp_fault, exp_lvl;
        de = rd(base + 32'(vpn[19:10]) * 4);
        if (!de[0]) begin
            exp_fault = 1; exp_lvl = 0; exp_pte = de;
        end else begin
            pe = rd((de & 32'hFFFF_F000) + 32'(vpn[9:0]) * 4);
            exp_pte = pe; exp_fault = !pe[0]; exp_lvl = 1;
        end
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1; miss_vpn = vpn; dir_base = base;
        @(negedge clk);
        miss_valid = 0;
        while (!resp_valid) @(negedge clk);
        chk(resp_fault == exp_fault, exp_lvl ? "R5/R6 walk fault" : "R4 walk fault",
            32'(resp_fault), 32'(exp_fault));
        chk(resp_pte == exp_pte, "R6 walk pte", resp_pte, exp_pte);
        if (exp_fault) chk(resp_lvl == exp_lvl, "R4/R5 walk lvl", 32'(resp_lvl), 32'(exp_lvl));
        @(negedge clk);
        chk(miss_ready == 1, "R10 ready after resp", 32'(miss_ready), 32'h1);
    endtask

    initial begin
        // directory at 0x10000; table for dir idx 0x001 at 0x20000
        pmem[32'h0001_0004] = 32'h0002_0001;
        pmem[32'h0002_0008] = 32'hABCDE00F;  // vpn 0x00402 present, user, rw
        pmem[32'h0002_000C] = 32'h1234_500E;  // vpn 0x00403 absent
        pmem[32'h0001_0FFC] = 32'h0003_0001;  // dir idx 0x3FF
        pmem[32'h0003_0FFC] = 32'h7777_7003;  // vpn 0xFFFFF present
        pmem[32'h0003_0000] = 32'h5555_5001;  // vpn 0xFFC00 present
        // dir idx 0x002 left absent

        repeat (3) @(negedge clk);
        chk(miss_ready == 1 && mem_req == 0 && resp_valid == 0, "R1 reset state",
            {29'b0, miss_ready, mem_req, resp_valid}, 32'h4);
        rst_n = 1;

        walk(20'h00402, 32'h0001_0000);           // R6 success
        lat = 3; stall_cfg = 2;
        walk(20'h00402, 32'h0001_0000);           // R7 stalls and latency
        walk(20'h00403, 32'h0001_0000);           // R5 table level
        lat = 0; stall_cfg = 0;
        walk(20'h00800, 32'h0001_0000);           // R4 directory level
        walk(20'hFFFFF, 32'h0001_0000);           // R3 top index edge
        walk(20'hFFC00, 32'h0001_0000);           // R2 low table index
        lat = 1; stall_cfg = 1;
        walk(20'h00002, 32'h0000_F004);           // R2 offset base, dir idx 0 -> 0xF004 absent

        // R9: stray responses while idle
        @(negedge clk);
        stray_req++;
        repeat (4) @(negedge clk);
        chk(miss_ready == 1 && resp_valid == 0, "R9 stray ignored",
            {30'b0, miss_ready, resp_valid}, 32'h2);

        // R8: miss held high through several walks
        lat = 2; stall_cfg = 1;
        @(negedge clk);
        miss_valid = 1; miss_vpn = 20'h00402; dir_base = 32'h0001_0000;
        @(negedge clk);
        chk(miss_ready == 0, "R8 busy not ready", 32'(miss_ready), 32'h0);
        miss_vpn = 20'h00403;
        repeat (40) @(negedge clk);
        miss_valid = 0;
        repeat (20) @(negedge clk);
        chk(miss_ready == 1, "R8 idle after held miss", 32'(miss_ready), 32'h1);

        finish_run();
    end
endmodule